// File: doc/BRIEF.md
# Synchronous SRAM switch-access controller

This block lets a small set of switches and one push button drive a single-port synchronous static RAM. The RAM holds 524,288 words of 36 bits, samples every control line on the rising clock edge, and has one data bus shared by reads and writes. Four switches give the word address. The remaining address bits are always zero. Four more switches give a value to store. An active-low button asks for a store. The block returns a 4-bit value read from the currently selected address so that a display can show it.

The memory accepts only the first read or write command after each address capture and ignores any repeats. Because of this, the controller can hold the read command as its resting state. A button press runs a fixed four-step command sequence: capture, write, capture, read. A change of the address switches while resting runs a two-step capture and read. The direction of the shared bus is given by a separate output.

The controller is a four-state machine:
- `ST_READ` is the resting read command.
- `ST_CAP_WR` is the capture before a write.
- `ST_WRITE` is the write command.
- `ST_CAP_RD` is the capture before a read.

The transitions are:
- `ST_READ` to `ST_CAP_WR` when a store is requested or pending. This has priority.
- `ST_READ` to `ST_CAP_RD` when the synchronized address differs from the last captured one.
- `ST_CAP_WR` to `ST_WRITE`, then `ST_WRITE` to `ST_CAP_RD`, then `ST_CAP_RD` to `ST_READ`, each unconditionally.

Top module: `ssram_panel_ctrl`

## Requirements
- R1: After reset the outputs show the resting read: `mem_oe_n`=0, `mem_cap_n`=1, `mem_we_n`=1, `mem_dq_dir`=1, `mem_addr`=0 and `rd_val`=0. No command sequence starts while the inputs keep their reset values.
- R2: `mem_addr` bits above bit 3 are always 0. Bits 3..0 carry the switch address taken when the sequence started.
- R3: The command encoding is as follows. Capture is `mem_cap_n`=0. Write is `mem_we_n`=0. Read is `mem_oe_n`=0 with the other two lines high. At most one command is active in any cycle. A falling edge of `wr_btn_n` gives capture, write, capture and read on consecutive cycles, all at one address. The read is then held.
- R4: A press that is held for many cycles gives exactly one write sequence. Releasing the button starts nothing.
- R5: During the write, bit 9*k of `mem_dq_o` carries `sw_wdata[k]` for k = 0..3. Every other bit of `mem_dq_o` is 0.
- R6: `rd_val[k]` is bus bit 9*k of `mem_dq_i`. All other bus bits have no effect on `rd_val`.
- R7: `rd_val` is loaded from `mem_dq_i` at the rising edge that ends the RD_LAT-th cycle after the first cycle of a read command (RD_LAT defaults to 2).
- R8: While resting, a change of `sw_addr` gives one capture of the new address followed by the read.
- R9: `mem_dq_dir` is 0 exactly in the write cycle and 1 at all other times.
- R10: While resting with unchanged inputs, no capture is issued and the read command stays asserted.
- R11: A press that arrives during a running sequence is held. It gets its own full write sequence once the first one returns to `ST_READ`.
- R12: An address change that arrives during a write sequence is served after that sequence by a capture and read of the new address. The write still lands at the old address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_addr | input | 4 | Address switches, asynchronous |
| sw_wdata | input | 4 | Store-value switches, asynchronous |
| wr_btn_n | input | 1 | Store button, active low, asynchronous |
| mem_addr | output | 19 | Memory word address |
| mem_cap_n | output | 1 | Address capture command, active low |
| mem_we_n | output | 1 | Write command, active low |
| mem_oe_n | output | 1 | Read command, active low |
| mem_dq_dir | output | 1 | Bus direction, 0 = drive toward memory |
| mem_dq_o | output | 36 | Bus word driven during the write |
| mem_dq_i | input | 36 | Bus word returned by the memory |
| rd_val | output | 4 | Value read from the selected address |

## Verification
A short press, a long hold, and two presses a couple of cycles apart separate edge detection from level detection. They also show whether a second request is dropped or kept pending. A plain address change and an address change in the middle of a write sequence show whether a capture goes to the right address, and whether the pending re-read follows the write. The memory words are preloaded with ones in every bit outside the four read positions, and with a pattern that differs from the stored values. This exposes a wrong bit pick and a read result taken one cycle early or late. An idle stretch shows that nothing is issued without an event.

// File: rtl/ssram_ctl_pkg.sv
package ssram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_READ   = 2'd0,
        ST_CAP_WR = 2'd1,
        ST_WRITE  = 2'd2,
        ST_CAP_RD = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic cap_n;
        logic we_n;
        logic oe_n;
        logic dq_dir;
    } mem_cmd_t;

endpackage

// File: rtl/ssram_sync.sv
module ssram_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ssram_seq_fsm.sv
module ssram_seq_fsm
    import ssram_ctl_pkg::*;
#(
    parameter int UA_W = 4,
    parameter int DV_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [UA_W-1:0] addr_s,
    input  logic [DV_W-1:0] wdat_s,
    output mem_cmd_t        cmd,
    output logic [UA_W-1:0] cur_addr,
    output logic [DV_W-1:0] wr_val,
    output logic            rd_issue
);
    seq_state_e state_q, state_d;
    logic       wr_pend_q;
    logic       rd_first_q;
    logic       take_wr;
    logic       take_rd;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ: begin
                if (wr_pend_q || wr_req)
                    state_d = ST_CAP_WR;
                else if (addr_s != cur_addr)
                    state_d = ST_CAP_RD;
            end
            ST_CAP_WR: state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_CAP_RD;
            ST_CAP_RD: state_d = ST_READ;
            default:   state_d = ST_READ;
        endcase
    end

    assign take_wr = (state_q == ST_READ) && (state_d == ST_CAP_WR);
    assign take_rd = (state_q == ST_READ) && (state_d == ST_CAP_RD);

    // state register and the values latched on leaving ST_READ
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_READ;
            wr_pend_q  <= 1'b0;
            cur_addr   <= '0;
            wr_val     <= '0;
            rd_first_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            wr_pend_q  <= take_wr ? (wr_pend_q & wr_req) : (wr_pend_q | wr_req);
            rd_first_q <= (state_q == ST_CAP_RD);
            if (take_wr) begin
                cur_addr <= addr_s;
                wr_val   <= wdat_s;
            end else if (take_rd) begin
                cur_addr <= addr_s;
            end
        end
    end

    // command lines per state
    always_comb begin
        cmd = '{cap_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_dir: 1'b1};
        unique case (state_q)
            ST_READ:   cmd.oe_n  = 1'b0;
            ST_CAP_WR: cmd.cap_n = 1'b0;
            ST_WRITE: begin
                cmd.we_n   = 1'b0;
                cmd.dq_dir = 1'b0;
            end
            ST_CAP_RD: cmd.cap_n = 1'b0;
            default:   cmd.oe_n  = 1'b0;
        endcase
    end

    assign rd_issue = rd_first_q;
endmodule

// File: rtl/ssram_rd_pipe.sv
module ssram_rd_pipe #(
    parameter int LAT    = 2,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_i,
    output logic [LANES-1:0]  rd_val
);
    localparam int LANE_W = DATA_W / LANES;

    logic [LAT-1:0]   pipe_q;
    logic [LANES-1:0] picked;
    logic             unused_bus;

    generate
        if (LAT == 1) begin : g_lat1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= issue;
            end
        end else begin : g_latn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[LAT-2:0], issue};
            end
        end
    endgenerate

    for (genvar g = 0; g < LANES; g++) begin : g_pick
        assign picked[g] = dq_i[g*LANE_W];
    end

    assign unused_bus = ^dq_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rd_val <= '0;
        else if (pipe_q[LAT-1])  rd_val <= picked;
    end
endmodule

// File: rtl/ssram_panel_ctrl.sv
module ssram_panel_ctrl
    import ssram_ctl_pkg::*;
#(
    parameter int MEM_AW = 19,
    parameter int DATA_W = 36,
    parameter int LANES  = 4,
    parameter int UA_W   = 4,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UA_W-1:0]   sw_addr,
    input  logic [LANES-1:0]  sw_wdata,
    input  logic              wr_btn_n,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_cap_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_dq_dir,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [LANES-1:0]  rd_val
);
    localparam int LANE_W = DATA_W / LANES;

    logic [UA_W-1:0]  addr_s;
    logic [LANES-1:0] wdat_s;
    logic             btn_s;
    logic             btn_q;
    logic             wr_req;
    mem_cmd_t         cmd;
    logic [UA_W-1:0]  cur_addr;
    logic [LANES-1:0] wr_val;
    logic             rd_issue;

    ssram_sync #(.W(UA_W), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(sw_addr), .q(addr_s));

    ssram_sync #(.W(LANES), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(sw_wdata), .q(wdat_s));

    ssram_sync #(.W(1), .RST_VAL(1'b1)) u_sync_btn (
        .clk(clk), .rst_n(rst_n), .d(wr_btn_n), .q(btn_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) btn_q <= 1'b1;
        else        btn_q <= btn_s;
    end

    assign wr_req = btn_q & ~btn_s;

    ssram_seq_fsm #(.UA_W(UA_W), .DV_W(LANES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .addr_s(addr_s),
        .wdat_s(wdat_s), .cmd(cmd), .cur_addr(cur_addr), .wr_val(wr_val),
        .rd_issue(rd_issue));

    ssram_rd_pipe #(.LAT(RD_LAT), .DATA_W(DATA_W), .LANES(LANES)) u_rd (
        .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_i(mem_dq_i),
        .rd_val(rd_val));

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign mem_dq_o[g*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, wr_val[g]};
    end

    assign mem_addr   = {{(MEM_AW-UA_W){1'b0}}, cur_addr};
    assign mem_cap_n  = cmd.cap_n;
    assign mem_we_n   = cmd.we_n;
    assign mem_oe_n   = cmd.oe_n;
    assign mem_dq_dir = cmd.dq_dir;
endmodule

// File: rtl/ssram_ctl_chk.sv
module ssram_ctl_chk #(
    parameter int MEM_AW = 19,
    parameter int UA_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_cap_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_dir
);
    // R9
    dir_in_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_dq_dir |-> (!mem_we_n && mem_cap_n && mem_oe_n));

    // R9
    write_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_dq_dir);

    // R3
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!mem_cap_n, !mem_we_n, !mem_oe_n}));

    // R3
    write_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $past(!mem_cap_n));

    // R3
    cap_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> !mem_cap_n);

    // R3
    write_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $stable(mem_addr));

    // R2
    addr_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[MEM_AW-1:UA_W] == '0);
endmodule

bind ssram_panel_ctrl ssram_ctl_chk #(.MEM_AW(MEM_AW), .UA_W(UA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_cap_n(mem_cap_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_dir(mem_dq_dir));

// File: tb/ssram_panel_ctrl_tb_top.sv
module ssram_panel_ctrl_tb_top;
    localparam int MEM_AW = 19;
    localparam int DATA_W = 36;
    localparam int LANES  = 4;
    localparam int UA_W   = 4;
    localparam int RD_LAT = 2;
    localparam int LANE_W = DATA_W / LANES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [UA_W-1:0]   sw_addr = '0;
    logic [LANES-1:0]  sw_wdata = '0;
    logic              wr_btn_n = 1'b1;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_cap_n, mem_we_n, mem_oe_n, mem_dq_dir;
    logic [DATA_W-1:0] mem_dq_o;
    logic [DATA_W-1:0] mem_dq_i = '0;
    logic [LANES-1:0]  rd_val;

    always #5 clk = ~clk;

    ssram_panel_ctrl #(.MEM_AW(MEM_AW), .DATA_W(DATA_W), .LANES(LANES),
                       .UA_W(UA_W), .RD_LAT(RD_LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .wr_btn_n(wr_btn_n), .mem_addr(mem_addr), .mem_cap_n(mem_cap_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_dir(mem_dq_dir),
        .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .rd_val(rd_val));

    int checks = 0;
    int errors = 0;

    // device model state
    logic [DATA_W-1:0]     dev_mem [16];
    logic [LANES-1:0]      shadow  [16];
    logic [UA_W+LANES-1:0] exp_wr [$];
    logic [UA_W-1:0]       dev_addr;
    bit                    armed = 0;
    int                    rd_cnt = 0;
    logic [UA_W-1:0]       rd_addr;
    bit                    upd_pend = 0;
    logic [LANES-1:0]      upd_val;
    logic [LANES-1:0]      exp_rd = '0;
    int                    log_code = 0;
    int                    prev_cls = 3;

    function automatic logic [DATA_W-1:0] pack_val(input logic [LANES-1:0] v);
        logic [DATA_W-1:0] w = '0;
        for (int k = 0; k < LANES; k++) w[k*LANE_W] = v[k];
        return w;
    endfunction

    function automatic logic [LANES-1:0] pick_val(input logic [DATA_W-1:0] w);
        logic [LANES-1:0] v;
        for (int k = 0; k < LANES; k++) v[k] = w[k*LANE_W];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // cycle-by-cycle reference: device behaviour plus expected read result
    always @(negedge clk) begin
        if (rst_n) begin
            int cls;
            if (upd_pend) begin
                exp_rd   = upd_val;
                upd_pend = 0;
            end
            chk(rd_val == exp_rd, "R7 rd_val per cycle", rd_val, exp_rd);
            chk(mem_dq_dir == mem_we_n, "R9 dir vs write", mem_dq_dir, mem_we_n);
            chk(mem_addr[MEM_AW-1:UA_W] == '0, "R2 high address bits", mem_addr, mem_addr[UA_W-1:0]);

            cls = !mem_cap_n ? 1 : (!mem_we_n ? 2 : (!mem_oe_n ? 3 : 0));
            if (cls != prev_cls) begin
                log_code = log_code * 10 + cls;
                prev_cls = cls;
            end

            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    mem_dq_i = dev_mem[rd_addr];
                    upd_val  = pick_val(dev_mem[rd_addr]);
                    upd_pend = 1;
                end
            end

            if (!mem_cap_n) begin
                dev_addr = mem_addr[UA_W-1:0];
                armed    = 1;
            end else if (!mem_we_n && armed) begin
                armed = 0;
                dev_mem[dev_addr] = mem_dq_o;
                if (exp_wr.size() == 0) begin
                    chk(0, "R3 unexpected write", dev_addr, -1);
                end else begin
                    logic [UA_W+LANES-1:0] e;
                    e = exp_wr.pop_front();
                    chk(dev_addr == e[UA_W+LANES-1:LANES], "R2 write address", dev_addr, e[UA_W+LANES-1:LANES]);
                    chk(mem_dq_o == pack_val(e[LANES-1:0]), "R5 write word", mem_dq_o, pack_val(e[LANES-1:0]));
                end
            end else if (!mem_oe_n && armed) begin
                armed   = 0;
                rd_addr = dev_addr;
                rd_cnt  = RD_LAT;
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_wr(input logic [UA_W-1:0] a, input logic [LANES-1:0] d);
        exp_wr.push_back({a, d});
        shadow[a] = d;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            logic [DATA_W-1:0] w = '1;
            logic [3:0] inv = ~i[3:0];
            for (int k = 0; k < LANES; k++) w[k*LANE_W] = inv[k];
            dev_mem[i] = w;
            shadow[i]  = inv;
        end
        settle(3);
        rst_n = 1'b1;
        settle(1);
        chk(mem_oe_n == 0 && mem_cap_n == 1 && mem_we_n == 1, "R1 reset commands",
            {mem_cap_n, mem_we_n, mem_oe_n}, 3'b110);
        chk(mem_dq_dir == 1, "R1 reset dir", mem_dq_dir, 1);
        chk(mem_addr == 0, "R1 reset addr", mem_addr, 0);
        chk(rd_val == 0, "R1 reset rd_val", rd_val, 0);
        settle(10);
        chk(log_code == 0, "R1 no sequence at reset", log_code, 0);

        // plain address change
        sw_addr = 4'd3; log_code = 0;
        settle(12);
        chk(log_code == 13, "R8 capture then read", log_code, 13);
        chk(rd_val == shadow[3], "R6 read of addr 3", rd_val, shadow[3]);

        // short press
        sw_wdata = 4'd5; settle(4);
        push_wr(4'd3, 4'd5); log_code = 0;
        wr_btn_n = 0; settle(2); wr_btn_n = 1;
        settle(12);
        chk(log_code == 1213, "R3 write sequence", log_code, 1213);
        chk(rd_val == 4'd5, "R6 read back after write", rd_val, 5);
        chk(exp_wr.size() == 0, "R5 write landed", exp_wr.size(), 0);

        // long hold
        sw_wdata = 4'd10; settle(4);
        push_wr(4'd3, 4'd10); log_code = 0;
        wr_btn_n = 0; settle(40);
        chk(log_code == 1213, "R4 held press one sequence", log_code, 1213);
        wr_btn_n = 1; settle(10);
        chk(log_code == 1213, "R4 release starts nothing", log_code, 1213);
        chk(rd_val == 4'd10, "R4 value after hold", rd_val, 10);

        // idle
        log_code = 0; settle(30);
        chk(log_code == 0, "R10 idle no capture", log_code, 0);
        chk(mem_oe_n == 0, "R10 read held", mem_oe_n, 0);

        // address change with ones in all other bus bits
        sw_addr = 4'd9; log_code = 0;
        settle(12);
        chk(log_code == 13, "R8 re-read on change", log_code, 13);
        chk(rd_val == shadow[9], "R6 other bus bits ignored", rd_val, shadow[9]);

        // two presses close together
        sw_wdata = 4'd7; settle(4);
        push_wr(4'd9, 4'd7); push_wr(4'd9, 4'd7); log_code = 0;
        wr_btn_n = 0; settle(1); wr_btn_n = 1; settle(1);
        wr_btn_n = 0; settle(1); wr_btn_n = 1;
        settle(16);
        chk(log_code == 12131213, "R11 pending press served", log_code, 12131213);
        chk(exp_wr.size() == 0, "R11 both writes landed", exp_wr.size(), 0);
        chk(rd_val == 4'd7, "R11 value", rd_val, 7);

        // address change during a write sequence
        sw_wdata = 4'd14; settle(4);
        push_wr(4'd9, 4'd14); log_code = 0;
        wr_btn_n = 0; settle(2);
        sw_addr = 4'd12; wr_btn_n = 1;
        settle(16);
        chk(log_code == 121313, "R12 re-read after write", log_code, 121313);
        chk(rd_val == shadow[12], "R12 new address value", rd_val, shadow[12]);
        sw_addr = 4'd9; settle(12);
        chk(rd_val == 4'd14, "R12 write kept old address", rd_val, 14);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule